// File: doc/BRIEF.md
# Multi-core Inter-Processor Interrupt Register Controller

This block holds one bank of interrupt registers for each core of a cluster and sits behind a single 32-bit register bus. A requester-ID input comes with every access and selects the bank that the access reaches. Each bank has a pending-status word that software cannot write directly, an enable word, a write-one-to-set port, a write-one-to-clear port, eight general-purpose 32-bit mailbox words, and one level interrupt output to its core.

A core signals another core by writing the send register in its own window. The written word names a target core and a vector number, and the block sets that vector's status bit in the target's bank. The interrupt output rises when a set leaves a pending bit that is also enabled. It falls only when a clear leaves the whole status word at zero while the enable word is nonzero. A requester or send target that names a core beyond the configured count gets a decode-error response, and that access changes nothing.

Top module: `ipiController`

## Requirements
- R1: After reset every status, enable and mailbox word reads zero and every interrupt output is low.
- R2: The enable word at offset 0x04 can be written and read back as written.
- R3: The set port (offset 0x08) and the clear port (offset 0x0C) always read back as zero.
- R4: A write to the set port ORs the data into status. On the next clock edge the core's interrupt goes high if status AND enable is then nonzero. Otherwise the interrupt keeps its level.
- R5: A write to the clear port clears the status bits given as ones in the data. The interrupt goes low on the next edge only if status is then all zero and enable is nonzero. Otherwise it keeps its level.
- R6: A write to the status word (offset 0x00) changes no state and raises `roWriteErr` for one cycle, one cycle after the write.
- R7: Offsets 0x20 to 0x3F hold eight mailbox words that can be read and written, with word index address bits 4:2. Each core has its own eight words.
- R8: A write to the send register (offset 0x40) takes a target core from data bits 25:16 and a vector from data bits 4:0, and sets status bit (1 << vector) in the target's bank with the same interrupt rule as R4. The sender's own bank is untouched.
- R9: A read or write whose requester ID is not below NUM_CORES returns a decode error and has no effect. A read in that case returns zero data.
- R10: A send whose target ID is not below NUM_CORES returns a decode error and sets no status bit in any bank.
- R11: A read of an offset that decodes to no register returns zero without a decode error, and a write to such an offset has no effect.
- R12: Every read gives exactly one response, with `busRdValid` high, in the cycle after the read was presented. The decode-error flag for any access appears in that same following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRdEn | input | 1 | Read request this cycle (ignored while busWrEn is high) |
| busWrEn | input | 1 | Write request this cycle |
| busAddr | input | 8 | Byte offset within the core window |
| busReqId | input | 10 | Requester core ID selecting the bank |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read response strobe, one cycle after a read |
| busDecErr | output | 1 | Decode error for the access of the previous cycle |
| roWriteErr | output | 1 | Pulse after an attempted write to the status word |
| coreIrq | output | NUM_CORES | Per-core interrupt level |

## Verification
The bench builds the block with NUM_CORES = 3. This count is not a power of two, so requester or target ID 3 still fits in the 2-bit bank index while lying outside the valid range. That exposes any decoder that checks bits instead of comparing against the core count. With three banks, a send can also cross from one core to a third bank while a neighbouring bank is watched for stray updates. Mailbox traffic to two cores shows whether each core's words stay separate.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int CORE_ID_W = 10;
  localparam int VEC_W     = 5;
  localparam int MBX_WORDS = 8;
  localparam int MBX_IDX_W = $clog2(MBX_WORDS);

  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;
  localparam logic [7:0] OFF_SEND   = 8'h40;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2,
    RD_MBX    = 2'd3
  } rdKind_e;

  // Strobes handed from the decoder to the register banks each cycle.
  typedef struct packed {
    logic                 enWr;
    logic                 setWr;
    logic                 clrWr;
    logic                 mbxWr;
    logic                 sendSet;
    logic                 rdStb;
    rdKind_e              rdKind;
    logic [CORE_ID_W-1:0] bankIdx;
    logic [CORE_ID_W-1:0] targetIdx;
    logic [MBX_IDX_W-1:0] mbxIdx;
    logic [VEC_W-1:0]     vector;
  } ctrlStrobes_t;

endpackage

// File: rtl/ipiCtrl.sv
module ipiCtrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [7:0]           addr,
  input  logic [CORE_ID_W-1:0] reqId,
  input  logic [CORE_ID_W-1:0] sendTarget,
  input  logic [VEC_W-1:0]     sendVector,
  output ctrlStrobes_t         strb,
  output logic                 rdValid,
  output logic                 decErr,
  output logic                 roErr
);

  localparam logic [CORE_ID_W-1:0] CORE_LIMIT = CORE_ID_W'(NUM_CORES);

  logic reqOk, tgtOk, isMbx, isSend, isStatus, accErr;
  logic rdValidQ, decErrQ, roErrQ;

  assign reqOk    = reqId < CORE_LIMIT;
  assign tgtOk    = sendTarget < CORE_LIMIT;
  assign isMbx    = addr[7:5] == 3'b001;
  assign isSend   = addr == OFF_SEND;
  assign isStatus = addr == OFF_STATUS;
  assign accErr   = (rdEn || wrEn) && (!reqOk || (wrEn && isSend && !tgtOk));

  always_comb begin
    strb           = '0;
    strb.bankIdx   = reqId;
    strb.targetIdx = sendTarget;
    strb.vector    = sendVector;
    strb.mbxIdx    = addr[4:2];
    strb.rdKind    = RD_ZERO;
    if (wrEn && reqOk) begin
      strb.enWr    = addr == OFF_ENABLE;
      strb.setWr   = addr == OFF_SET;
      strb.clrWr   = addr == OFF_CLEAR;
      strb.mbxWr   = isMbx;
      strb.sendSet = isSend && tgtOk;
    end else if (rdEn && reqOk) begin
      strb.rdStb = 1'b1;
      if (isStatus)                 strb.rdKind = RD_STATUS;
      else if (addr == OFF_ENABLE)  strb.rdKind = RD_ENABLE;
      else if (isMbx)               strb.rdKind = RD_MBX;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      decErrQ  <= 1'b0;
      roErrQ   <= 1'b0;
    end else begin
      rdValidQ <= rdEn && !wrEn;
      decErrQ  <= accErr;
      roErrQ   <= wrEn && reqOk && isStatus;
    end
  end

  assign rdValid = rdValidQ;
  assign decErr  = decErrQ;
  assign roErr   = roErrQ;

endmodule

// File: rtl/ipiDatapath.sv
module ipiDatapath
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic [NUM_CORES-1:0] irq
);

  logic [NUM_CORES-1:0][31:0]                statusVec;
  logic [NUM_CORES-1:0][31:0]                enableVec;
  logic [NUM_CORES-1:0][MBX_WORDS-1:0][31:0] mbxVec;
  logic [31:0] vecMask;
  logic [31:0] rdMux;
  logic [31:0] rdDataQ;

  assign vecMask = 32'(1) << strb.vector;

  for (genvar c = 0; c < NUM_CORES; c++) begin : gBank
    logic                       hit, sendHit, anySet, anyClr;
    logic [31:0]                setMask, clrMask, statusNext;
    logic [31:0]                statusQ, enableQ;
    logic [MBX_WORDS-1:0][31:0] mbxQ;
    logic                       irqQ, irqNext;

    assign hit     = strb.bankIdx == CORE_ID_W'(c);
    assign sendHit = strb.sendSet && (strb.targetIdx == CORE_ID_W'(c));
    assign anySet  = (strb.setWr && hit) || sendHit;
    assign anyClr  = strb.clrWr && hit;
    assign setMask = ((strb.setWr && hit) ? wrData : 32'h0) | (sendHit ? vecMask : 32'h0);
    assign clrMask = anyClr ? wrData : 32'h0;
    // Clear first, then set: a set arriving with a clear survives it.
    assign statusNext = (statusQ & ~clrMask) | setMask;

    always_comb begin
      irqNext = irqQ;
      if (anySet && ((statusNext & enableQ) != 32'h0))
        irqNext = 1'b1;
      else if (anyClr && (statusNext == 32'h0) && (enableQ != 32'h0))
        irqNext = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ <= '0;
        enableQ <= '0;
        mbxQ    <= '0;
        irqQ    <= 1'b0;
      end else begin
        statusQ <= statusNext;
        irqQ    <= irqNext;
        if (strb.enWr && hit) enableQ <= wrData;
        if (strb.mbxWr && hit) mbxQ[strb.mbxIdx] <= wrData;
      end
    end

    assign statusVec[c] = statusQ;
    assign enableVec[c] = enableQ;
    assign mbxVec[c]    = mbxQ;
    assign irq[c]       = irqQ;
  end

  always_comb begin
    rdMux = 32'h0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (strb.bankIdx == CORE_ID_W'(c)) begin
        unique case (strb.rdKind)
          RD_STATUS: rdMux = statusVec[c];
          RD_ENABLE: rdMux = enableVec[c];
          RD_MBX:    rdMux = mbxVec[c][strb.mbxIdx];
          default:   rdMux = 32'h0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdDataQ <= '0;
    else       rdDataQ <= strb.rdStb ? rdMux : 32'h0;
  end

  assign rdData = rdDataQ;

endmodule

// File: rtl/ipiController.sv
module ipiController
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busRdEn,
  input  logic                 busWrEn,
  input  logic [7:0]           busAddr,
  input  logic [9:0]           busReqId,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic                 busRdValid,
  output logic                 busDecErr,
  output logic                 roWriteErr,
  output logic [NUM_CORES-1:0] coreIrq
);

  ctrlStrobes_t strb;

  ipiCtrl #(.NUM_CORES(NUM_CORES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdEn       (busRdEn),
    .wrEn       (busWrEn),
    .addr       (busAddr),
    .reqId      (busReqId),
    .sendTarget (busWrData[25:16]),
    .sendVector (busWrData[4:0]),
    .strb       (strb),
    .rdValid    (busRdValid),
    .decErr     (busDecErr),
    .roErr      (roWriteErr)
  );

  ipiDatapath #(.NUM_CORES(NUM_CORES)) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .rdData (busRdData),
    .irq    (coreIrq)
  );

endmodule

// File: rtl/ipiCheck.sv
module ipiCheck #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busRdEn,
  input logic                 busWrEn,
  input logic [7:0]           busAddr,
  input logic [9:0]           busReqId,
  input logic [31:0]          busRdData,
  input logic                 busRdValid,
  input logic                 busDecErr,
  input logic                 roWriteErr,
  input logic [NUM_CORES-1:0] coreIrq
);

  assert_rd_resp_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn) |=> busRdValid);

  assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && !busWrEn) |=> !busRdValid);

  assert_decerr_needs_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn || busWrEn) |=> !busDecErr);

  assert_bad_req_zero_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && busReqId >= 10'(NUM_CORES)) |=> (busDecErr && busRdData == 32'h0));

  assert_ro_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    roWriteErr |-> $past(busWrEn && busAddr == 8'h00));

  assert_irq_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(coreIrq));

  for (genvar c = 0; c < NUM_CORES; c++) begin : gIrq
    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(coreIrq[c]) |-> $past(busWrEn && (busAddr == 8'h08 || busAddr == 8'h40)));

    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(coreIrq[c]) |-> $past(busWrEn && busAddr == 8'h0C && busReqId == 10'(c)));
  end

endmodule

bind ipiController ipiCheck #(.NUM_CORES(NUM_CORES)) uIpiCheck (
  .clk        (clk),
  .rstN       (rstN),
  .busRdEn    (busRdEn),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busReqId   (busReqId),
  .busRdData  (busRdData),
  .busRdValid (busRdValid),
  .busDecErr  (busDecErr),
  .roWriteErr (roWriteErr),
  .coreIrq    (coreIrq)
);

// File: tb/tb_ipiController.sv
`timescale 1ns/1ps
module tb_ipiController;

  localparam int NC = 3;
  localparam logic [7:0] A_ST = 8'h00, A_EN = 8'h04, A_SET = 8'h08, A_CLR = 8'h0C;
  localparam logic [7:0] A_MBX = 8'h20, A_SEND = 8'h40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busRdEn = 1'b0, busWrEn = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [9:0]    busReqId = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          busRdValid, busDecErr, roWriteErr;
  logic [NC-1:0] coreIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } expRd_t;
  expRd_t expQ[$];

  always #10 clk = ~clk;

  ipiController #(.NUM_CORES(NC)) dut (
    .clk(clk), .rstN(rstN), .busRdEn(busRdEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busReqId(busReqId), .busWrData(busWrData),
    .busRdData(busRdData), .busRdValid(busRdValid), .busDecErr(busDecErr),
    .roWriteErr(roWriteErr), .coreIrq(coreIrq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item for each read response.
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) begin
        check(32'h1, 32'h0, "R12 unexpected read response");
      end else begin
        expRd_t e;
        e = expQ.pop_front();
        check(busRdData, e.data, e.tag);
        check({31'h0, busDecErr}, {31'h0, e.err}, {e.tag, " decode error"});
      end
    end
  end

  task automatic wr(input int req, input logic [7:0] a, input logic [31:0] d,
                    input logic expErr, input string tag);
    busReqId = 10'(req); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check({31'h0, busDecErr}, {31'h0, expErr}, {tag, " write decode error"});
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp,
                    input logic expErr, input string tag);
    expRd_t e;
    e.data = exp; e.err = expErr; e.tag = tag;
    expQ.push_back(e);
    busReqId = 10'(req); busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic [31:0] sendWord(input int tgt, input int vec);
    return 32'h4000_0100 | (32'(tgt & 10'h3FF) << 16) | 32'(vec & 31);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(32'(coreIrq), 32'h0, "R1 irq in reset");
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(32'(coreIrq), 32'h0, "R1 irq after reset");
    for (int c = 0; c < NC; c++) begin
      rd(c, A_ST, 32'h0, 1'b0, "R1 status reset");
      rd(c, A_EN, 32'h0, 1'b0, "R1 enable reset");
    end
    rd(1, A_MBX + 8'h1C, 32'h0, 1'b0, "R1 mailbox reset");

    // R2: enable write/read
    wr(0, A_EN, 32'h0000_00F0, 1'b0, "R2");
    rd(0, A_EN, 32'h0000_00F0, 1'b0, "R2 enable readback");

    // R4: set without enabled bit keeps irq low, then enabled bit raises it
    wr(0, A_SET, 32'h0000_0001, 1'b0, "R4");
    check(32'(coreIrq), 32'h0, "R4 masked set keeps irq low");
    rd(0, A_ST, 32'h0000_0001, 1'b0, "R4 status after set");
    wr(0, A_SET, 32'h0000_0010, 1'b0, "R4");
    check(32'(coreIrq), 32'h1, "R4 enabled set raises irq");
    rd(0, A_ST, 32'h0000_0011, 1'b0, "R4 status OR");

    // R3: set and clear ports read zero
    rd(0, A_SET, 32'h0, 1'b0, "R3 set reads zero");
    rd(0, A_CLR, 32'h0, 1'b0, "R3 clear reads zero");

    // R5: partial clear keeps irq, full clear drops it
    wr(0, A_CLR, 32'h0000_0010, 1'b0, "R5");
    check(32'(coreIrq), 32'h1, "R5 partial clear keeps irq");
    rd(0, A_ST, 32'h0000_0001, 1'b0, "R5 status after partial clear");
    wr(0, A_CLR, 32'h0000_0001, 1'b0, "R5");
    check(32'(coreIrq), 32'h0, "R5 full clear drops irq");

    // R6: status write ignored and flagged
    wr(0, A_ST, 32'hFFFF_FFFF, 1'b0, "R6");
    check({31'h0, roWriteErr}, 32'h1, "R6 read-only flag");
    rd(0, A_ST, 32'h0, 1'b0, "R6 status unchanged");
    check({31'h0, roWriteErr}, 32'h0, "R6 flag is one cycle");

    // R7: mailboxes per core
    for (int w = 0; w < 8; w++)
      wr(1, A_MBX + 8'(w * 4), 32'hA500_0000 | 32'(w), 1'b0, "R7");
    wr(2, A_MBX + 8'h0C, 32'h1234_5678, 1'b0, "R7");
    for (int w = 0; w < 8; w++)
      rd(1, A_MBX + 8'(w * 4), 32'hA500_0000 | 32'(w), 1'b0, "R7 mailbox core1");
    rd(2, A_MBX + 8'h0C, 32'h1234_5678, 1'b0, "R7 mailbox core2");
    rd(2, A_MBX + 8'h08, 32'h0, 1'b0, "R7 mailbox core2 other word");

    // R11: undecoded offsets
    wr(0, 8'h44, 32'hDEAD_BEEF, 1'b0, "R11");
    rd(0, 8'h44, 32'h0, 1'b0, "R11 undecoded 0x44");
    rd(0, 8'h10, 32'h0, 1'b0, "R11 undecoded 0x10");
    rd(0, A_SEND, 32'h0, 1'b0, "R11 send reads zero");

    // R8: send from core0 to core2, vector 31
    wr(2, A_EN, 32'h8000_0000, 1'b0, "R8");
    wr(0, A_SEND, sendWord(2, 31), 1'b0, "R8");
    check(32'(coreIrq), 32'h4, "R8 send raises target irq");
    rd(2, A_ST, 32'h8000_0000, 1'b0, "R8 target status");
    rd(0, A_ST, 32'h0, 1'b0, "R8 sender status untouched");
    wr(1, A_SEND, sendWord(0, 4), 1'b0, "R8");
    rd(0, A_ST, 32'h0000_0010, 1'b0, "R8 vector 4 to core0");
    check(32'(coreIrq), 32'h5, "R8 core0 irq from send");

    // R10: bad targets
    wr(0, A_SEND, sendWord(3, 2), 1'b1, "R10 target 3");
    wr(0, A_SEND, sendWord(1023, 2), 1'b1, "R10 target 1023");
    rd(1, A_ST, 32'h0, 1'b0, "R10 core1 untouched");
    rd(0, A_ST, 32'h0000_0010, 1'b0, "R10 core0 untouched");
    rd(2, A_ST, 32'h8000_0000, 1'b0, "R10 core2 untouched");

    // R9: bad requester
    wr(3, A_SET, 32'hFFFF_FFFF, 1'b1, "R9 write req 3");
    wr(5, A_EN, 32'hFFFF_FFFF, 1'b1, "R9 write req 5");
    rd(5, A_ST, 32'h0, 1'b1, "R9 read req 5");
    rd(3, A_MBX, 32'h0, 1'b1, "R9 read req 3");
    rd(0, A_EN, 32'h0000_00F0, 1'b0, "R9 core0 enable untouched");
    check(32'(coreIrq), 32'h5, "R9 irq untouched");

    // R5: clear to zero with enable zero leaves irq high
    wr(1, A_EN, 32'h0000_0004, 1'b0, "R5");
    wr(1, A_SET, 32'h0000_0004, 1'b0, "R5");
    check(32'(coreIrq), 32'h7, "R5 core1 irq up");
    wr(1, A_EN, 32'h0, 1'b0, "R5");
    wr(1, A_CLR, 32'h0000_0004, 1'b0, "R5");
    check(32'(coreIrq), 32'h7, "R5 enable zero holds irq");
    wr(1, A_EN, 32'h0000_0004, 1'b0, "R5");
    wr(1, A_CLR, 32'h0, 1'b0, "R5");
    check(32'(coreIrq), 32'h5, "R5 zero status with enable drops irq");

    @(negedge clk);
    @(negedge clk);
    check(32'(expQ.size()), 32'h0, "R12 all reads answered");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule